// File: doc/BRIEF.md
# Heartbeat Watchdog With Supply Override

This block watches a heartbeat line that a processor toggles while its software runs normally. Every change of level on that line, rising or falling, restarts a countdown. If the countdown runs out before the next change arrives, the active-low alarm output `wdo_n` drops. It then stays low until the heartbeat changes again. The countdown length is a parameter in clock cycles. At a 200 MHz clock the default equals a 1.6 s period.

The heartbeat level arrives asynchronously and passes through a short synchroniser chain. A one-cycle level compare follows, and it treats any single sampled change as an edge with no filtering. Two conditions hold the timer cleared and idle: a flag that says the heartbeat line is floating, and a flag that says system reset is active. After either condition is removed, the timer stays idle until the first heartbeat change starts it.

A separate supply-good flag overrides the output. While the supply is bad, `wdo_n` is low. When the supply recovers, the output returns high in the same cycle, with no stretching. Feeding `wdo_n` back into a manual reset is left to the surrounding logic.

Top module: `hbw_top`

## Requirements
- R1: After the register reset `rst_n` is released with the supply good, `wdo_n` is 1. The timer stays idle, and `wdo_n` stays 1, for any length of time until a heartbeat change is seen.
- R2: A rising change of `hb_raw` restarts the countdown from zero. When changes arrive at most TIMEOUT cycles apart, `wdo_n` stays 1.
- R3: A falling change of `hb_raw` restarts the countdown exactly as a rising change does.
- R4: `hb_raw` changes just before clock edge k. If no further change or hold follows, `wdo_n` is 1 after edge k+TIMEOUT+1 and 0 after edge k+TIMEOUT+2. The count never exceeds TIMEOUT.
- R5: After a timeout, `wdo_n` stays 0 for as long as no change and no hold arrive. A change just before edge j makes `wdo_n` 1 after edge j+2, and it is still 0 after edge j+1.
- R6: While `hb_float` is 1, the timer is cleared and idle, and `wdo_n` is 1 from the first clock edge on. Heartbeat changes during that time have no effect. After release, the timer stays idle until the next change.
- R7: While `sys_rst_act` is 1, the timer is cleared and idle, just as for R6. Counting resumes only after release and a following heartbeat change, and it then times out per R4.
- R8: When `supply_ok` is 0, `wdo_n` is 0 in the same cycle. When `supply_ok` returns to 1, `wdo_n` goes back in the same cycle to the value the timer gives.
- R9: A heartbeat pulse that lasts a single clock period counts as two changes. It clears an expired timer, and the countdown then restarts from the pulse's trailing change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| hb_raw | input | 1 | Asynchronous heartbeat level from the processor |
| hb_float | input | 1 | 1 when the heartbeat line is detected as floating |
| sys_rst_act | input | 1 | 1 while system reset is asserted |
| supply_ok | input | 1 | 1 while the supply is above the reset threshold |
| wdo_n | output | 1 | Active-low timeout alarm |

## Verification
A heartbeat change takes two synchroniser cycles to reach the edge compare and one more cycle to clear the counter. So a restart shows at `wdo_n` two edges after the change, and a timeout shows TIMEOUT+2 edges after it. The holds act one edge after they are applied, and the supply override acts within the same cycle. The bench drives and samples on the falling clock edge and counts falling edges from each stimulus. It checks the last cycle in which the old value must remain and the first cycle in which the new value must appear. It sweeps every toggle spacing from 1 to TIMEOUT over a reduced TIMEOUT of 12.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RUN     = 2'd1,
        PH_EXPIRED = 2'd2
    } phase_e;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    assign chain_d[0] = d;
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbw_edge.sv
module hbw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic change
);
    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = level;
        change = (level != prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hbw_counter.sv
module hbw_counter
    import hbw_pkg::*;
#(
    parameter int TIMEOUT = 12,
    parameter int CW      = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          restart,
    output logic          expired,
    output phase_e        phase,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
    localparam logic [CW-1:0] ONE   = CW'(1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d;
    tmr_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (restart) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
        end else begin
            case (st_q.phase)
                PH_RUN: begin
                    st_d.cnt = st_q.cnt + ONE;
                    if (st_q.cnt + ONE >= LIMIT) begin
                        st_d.phase = PH_EXPIRED;
                        st_d.cnt   = LIMIT;
                    end
                end
                PH_EXPIRED: st_d = st_q;
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign expired = (st_q.phase == PH_EXPIRED);
    assign phase   = st_q.phase;
    assign cnt     = st_q.cnt;
endmodule

// File: rtl/hbw_top.sv
module hbw_top
    import hbw_pkg::*;
#(
    parameter int TIMEOUT     = 320_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_raw,
    input  logic hb_float,
    input  logic sys_rst_act,
    input  logic supply_ok,
    output logic wdo_n
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic          hb_sync;
    logic          edge_pulse;
    logic          hold;
    logic          expired;
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    hbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hb_raw),
        .q     (hb_sync)
    );

    hbw_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (hb_sync),
        .change (edge_pulse)
    );

    assign hold = hb_float | sys_rst_act;

    hbw_counter #(.TIMEOUT(TIMEOUT), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .restart (edge_pulse),
        .expired (expired),
        .phase   (phase_q),
        .cnt     (cnt_q)
    );

    assign wdo_n = supply_ok & ~expired;
endmodule

// File: rtl/hbw_checker.sv
module hbw_checker
    import hbw_pkg::*;
#(
    parameter int TIMEOUT = 12,
    parameter int CW      = $clog2(TIMEOUT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          hold,
    input logic          edge_pulse,
    input logic          wdo_n,
    input phase_e        phase_q,
    input logic [CW-1:0] cnt_q
);
    assert_supply_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wdo_n);

    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (phase_q == PH_IDLE && cnt_q == '0));

    assert_edge_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse && !hold) |=> (phase_q == PH_RUN && cnt_q == '0));

    assert_expired_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXPIRED && !edge_pulse && !hold) |=> (phase_q == PH_EXPIRED));

    assert_idle_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !edge_pulse) |=> (phase_q == PH_IDLE));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TIMEOUT));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && !edge_pulse && !hold) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

bind hbw_top hbw_checker #(.TIMEOUT(TIMEOUT), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .hold       (hold),
    .edge_pulse (edge_pulse),
    .wdo_n      (wdo_n),
    .phase_q    (phase_q),
    .cnt_q      (cnt_q)
);

// File: tb/tb_hbw_top.sv
`timescale 1ns/1ps
module tb_hbw_top;
    localparam int T = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_raw = 1'b0;
    logic hb_float = 1'b0;
    logic sys_rst_act = 1'b0;
    logic supply_ok = 1'b1;
    logic wdo_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbw_top #(.TIMEOUT(T), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hb_raw      (hb_raw),
        .hb_float    (hb_float),
        .sys_rst_act (sys_rst_act),
        .supply_ok   (supply_ok),
        .wdo_n       (wdo_n)
    );

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (wdo_n !== exp) begin
            errors++;
            $display("FAIL %s: wdo_n actual %b expected %b at %0t", tag, wdo_n, exp, $time);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // change then wait: after m waits the state reflects edge k+m-1
    task automatic expire_from_change(input string tag);
        hb_raw = ~hb_raw;
        waitn(T + 2);
        chk(1'b1, tag);
        waitn(1);
        chk(1'b0, tag);
    endtask

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        chk(1'b1, "R1 reset state");
        waitn(3 * T);
        chk(1'b1, "R1 idle before first change");

        // R2/R3: sweep every toggle spacing from 1 to T
        for (int p = 1; p <= T; p++) begin
            for (int n = 0; n < 4; n++) begin
                hb_raw = ~hb_raw;
                for (int c = 0; c < p; c++) begin
                    waitn(1);
                    chk(1'b1, hb_raw ? "R2 rising toggles" : "R3 falling toggles");
                end
            end
        end
        // let the last restart settle then time out to reach a known state
        waitn(T + 4);
        chk(1'b0, "R4 timeout after sweep");

        // R4 exact timing, rising change
        if (hb_raw) begin hb_raw = 1'b0; waitn(3); end
        expire_from_change("R4 rising exact");
        waitn(2 * T);
        chk(1'b0, "R5 saturated low");

        // R5 clear by falling change, then R3 exact timing with falling
        hb_raw = ~hb_raw;
        waitn(2);
        chk(1'b0, "R5 still low edge j+1");
        waitn(1);
        chk(1'b1, "R5 high edge j+2");
        waitn(T + 2);
        chk(1'b0, "R3 falling-started timeout");
        if (!hb_raw) begin hb_raw = 1'b1; waitn(T + 4); end
        expire_from_change("R3 falling exact");

        // R9 single-cycle pulse
        hb_raw = ~hb_raw;
        waitn(1);
        hb_raw = ~hb_raw;
        waitn(2);
        chk(1'b1, "R9 pulse clears");
        waitn(T);
        chk(1'b1, "R9 restart from trailing change");
        waitn(1);
        chk(1'b0, "R9 trailing timeout");

        // R6 float hold
        hb_float = 1'b1;
        waitn(1);
        chk(1'b1, "R6 float clears");
        for (int n = 0; n < 5; n++) begin
            hb_raw = ~hb_raw;
            waitn(T);
            chk(1'b1, "R6 changes ignored while float");
        end
        hb_float = 1'b0;
        waitn(3 * T);
        chk(1'b1, "R6 idle after float release");

        // R7 system reset hold
        expire_from_change("R4 before sysrst");
        sys_rst_act = 1'b1;
        waitn(1);
        chk(1'b1, "R7 sysrst clears");
        hb_raw = ~hb_raw;
        waitn(3 * T);
        chk(1'b1, "R7 no count during sysrst");
        sys_rst_act = 1'b0;
        waitn(3 * T);
        chk(1'b1, "R7 idle after release");
        expire_from_change("R7 counting after change");

        // R8 supply override
        #1;
        supply_ok = 1'b0;
        #0.5;
        chk(1'b0, "R8 supply low while expired");
        hb_raw = ~hb_raw;
        waitn(4);
        #1;
        chk(1'b0, "R8 supply low overrides running");
        supply_ok = 1'b1;
        #0.5;
        chk(1'b1, "R8 immediate recovery");
        supply_ok = 1'b0;
        #0.5;
        chk(1'b0, "R8 immediate drop");
        supply_ok = 1'b1;
        waitn(T);
        chk(1'b0, "R8 timer kept counting under override");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule